// File: doc/BRIEF.md
# Configurable SPI Slave Controller

This block is a register-mapped SPI target. An external controller selects it through a chip-select pin and clocks characters in on MOSI and out on MISO. A character is 8 or 16 bits long and is shifted most significant bit first. The select level, clock polarity, clock phase and character length are set in an 8-bit setup register. The block samples every serial pin on its own system clock, so the serial clock has to run well below that clock: at least about eight system cycles per serial clock phase.

Software writes the next outgoing character through one 16-bit data address and reads the last received character from the same address. The transmit and receive buffers are separate storage. The block keeps three status flags: character done, overrun and write collision. Software clears each flag by writing a 0 to its bit. One interrupt line asserts while the interrupt is enabled and any flag is set. A clock-divider byte is also present; it only holds and returns the value written to it.

Top module: `spi_slv_ctrl`

## Requirements
- R1: After reset, every register at all four addresses reads 0, and `irq` and `spi_miso` are 0.
- R2: The setup register at address 0 has these fields: bit 7 enables the interrupt, bit 6 sets the select level, bit 2 sets the character length, bit 1 sets the phase and bit 0 sets the polarity. Bits 5:3 always read 0, and writes to them are ignored.
- R3: Address 1 holds an 8-bit divider value that reads back as written. Its value has no effect on transfers.
- R4: The select is active when `spi_sel` equals setup bit 6. While it is inactive, `spi_sck` edges have no effect and `spi_miso` is 0.
- R5: Setup bit 0 picks the active edge: 0 means rising and 1 means falling. The leading edge of each clock pulse is the active edge. Setup bit 1 picks the sampling edge: 0 samples on the active edge and 1 samples on the inactive edge. MISO changes on the other edge. Data is shifted MSB first in every mode.
- R6: With setup bit 2 at 1, a character is 16 bits. The block sends the transmit buffer bits 15:0 and receives 16 bits.
- R7: With setup bit 2 at 0, a character is 8 bits. The block sends transmit bits 7:0, and the received value has bits 15:8 equal to 0.
- R8: At address 2, a write loads the transmit buffer and a read returns the last received character. The two buffers are independent.
- R9: A write to address 2 while the select is active is discarded and sets the write-collision flag, which is status bit 2 at address 3.
- R10: The done flag, status bit 0, sets when the last bit of a character is sampled. Several characters may follow one another within a single select period.
- R11: If a character completes while the done flag is still set, the overrun flag (status bit 1) sets and the receive buffer keeps its old value.
- R12: Writing 0 to a status bit clears that flag, and writing 1 leaves it unchanged. Status bit 3 always reads 0.
- R13: `irq` is 1 exactly when setup bit 7 is set and any status flag is set.
- R14: If the select goes inactive in the middle of a character, that character is dropped without completing. The next select period starts a fresh character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address (0 setup, 1 divider, 2 data, 3 status) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| spi_sel | input | 1 | Chip select pin, level set by the setup register |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, 0 when not selected |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all four clock modes, both character lengths and both select levels. It uses two data patterns, so every bit position sees both values. A wrong edge choice in any mode shows up as a bit offset in MISO or in the received word. The 8-bit cases show whether the high byte leaks out or gets received, and the two select levels show whether the polarity bit is honoured. Separate directed patterns cover the remaining cases: back-to-back characters for overrun, a write during a transfer for collision, clock toggles with the select inactive, and an aborted partial character. Each of these separates one flag or rule from the normal completion path.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
    localparam int DATA_W  = 16;
    localparam int SHORT_W = 8;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    typedef struct packed {
        logic ie;
        logic act_hi;
        logic wide;
        logic pha;
        logic pol;
    } cfg_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
    import spi_slv_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SHORT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg_i,
    input  logic          sel_i,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic [DW-1:0] tx_i,
    output logic          miso_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] tx_sh;
        logic [DW-1:0] rx_sh;
        logic          sck_prev;
        logic          sel_prev;
    } sh_t;

    sh_t sh_d, sh_q;
    logic edge_any, lead, trail, smp_edge, sft_edge;
    logic [CW-1:0] last_idx;
    logic [DW-1:0] rx_next;

    always_comb begin
        sh_d     = sh_q;
        done_o   = 1'b0;
        edge_any = sck_i != sh_q.sck_prev;
        lead     = edge_any && (sck_i != cfg_i.pol);
        trail    = edge_any && (sck_i == cfg_i.pol);
        smp_edge = cfg_i.pha ? trail : lead;
        sft_edge = cfg_i.pha ? lead : trail;
        last_idx = cfg_i.wide ? CW'(DW-1) : CW'(SW-1);
        rx_next  = {sh_q.rx_sh[DW-2:0], mosi_i};

        sh_d.sck_prev = sck_i;
        sh_d.sel_prev = sel_i;

        if (!sel_i) begin
            sh_d.cnt = '0;
        end else if (!sh_q.sel_prev) begin
            sh_d.cnt   = '0;
            sh_d.tx_sh = tx_i;
        end else if (smp_edge) begin
            sh_d.rx_sh = rx_next;
            if (sh_q.cnt == last_idx) begin
                done_o     = 1'b1;
                sh_d.cnt   = '0;
                sh_d.tx_sh = tx_i;
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end else if (sft_edge && sh_q.cnt != '0) begin
            sh_d.tx_sh = {sh_q.tx_sh[DW-2:0], 1'b0};
        end

        rx_o   = cfg_i.wide ? rx_next : {{(DW-SW){1'b0}}, rx_next[SW-1:0]};
        miso_o = sel_i && (cfg_i.wide ? sh_q.tx_sh[DW-1] : sh_q.tx_sh[SW-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R10
    done_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sel_i && sh_q.sel_prev);

    // R14
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> sh_q.cnt == '0);

    // R4
    idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> !miso_o);
endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
    import spi_slv_pkg::*;
#(
    parameter int DW          = DATA_W,
    parameter int SW          = SHORT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              spi_sel,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              irq
);
    typedef struct packed {
        cfg_t          cfg;
        logic [7:0]    div;
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
        logic          done;
        logic          ovr;
        logic          wcol;
    } st_t;

    st_t st_d, st_q;
    logic [2:0] pin_s;
    logic sel_act, sh_done;
    logic [DW-1:0] sh_rx;

    spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sel, spi_sck, spi_mosi}),
        .sync_o  (pin_s)
    );

    assign sel_act = pin_s[2] == st_q.cfg.act_hi;

    spi_slv_shift #(.DW(DW), .SW(SW)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_i  (st_q.cfg),
        .sel_i  (sel_act),
        .sck_i  (pin_s[1]),
        .mosi_i (pin_s[0]),
        .tx_i   (st_q.tx),
        .miso_o (spi_miso),
        .done_o (sh_done),
        .rx_o   (sh_rx)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            unique case (reg_addr)
                A_CFG: st_d.cfg = '{ie: reg_wdata[7], act_hi: reg_wdata[6],
                                    wide: reg_wdata[2], pha: reg_wdata[1],
                                    pol: reg_wdata[0]};
                A_DIV: st_d.div = reg_wdata[7:0];
                A_DATA: begin
                    if (sel_act) st_d.wcol = 1'b1;
                    else         st_d.tx   = reg_wdata;
                end
                A_STAT: begin
                    st_d.done = st_q.done & reg_wdata[0];
                    st_d.ovr  = st_q.ovr  & reg_wdata[1];
                    st_d.wcol = st_q.wcol & reg_wdata[2];
                end
                default: ;
            endcase
        end
        if (sh_done) begin
            if (st_d.done) st_d.ovr = 1'b1;
            else           st_d.rx  = sh_rx;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CFG:  reg_rdata[7:0] = {st_q.cfg.ie, st_q.cfg.act_hi, 3'b000,
                                      st_q.cfg.wide, st_q.cfg.pha, st_q.cfg.pol};
            A_DIV:  reg_rdata[7:0] = st_q.div;
            A_DATA: reg_rdata      = st_q.rx;
            A_STAT: reg_rdata[3:0] = {1'b0, st_q.wcol, st_q.ovr, st_q.done};
            default: ;
        endcase
    end

    assign irq = st_q.cfg.ie && (st_q.done || st_q.ovr || st_q.wcol);

    // R9
    wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_DATA && sel_act |=> st_q.wcol && $stable(st_q.tx));

    // R13
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.ie |-> !irq);

    // R11
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done && st_q.done && !(reg_wr && reg_addr == A_STAT)
        |=> st_q.ovr && $stable(st_q.rx));

    // R12
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_STAT && !reg_wdata[0] && !sh_done |=> !st_q.done);
endmodule

// File: tb/spi_slv_ctrl_tb_top.sv
module spi_slv_ctrl_tb_top;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        spi_sel = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    spi_slv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sel(spi_sel),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One character of nbits, sent MSB first from mo, captured into mi.
    task automatic bits(input bit pol, input bit pha, input int nbits,
                        input logic [15:0] mo, inout logic [15:0] mi);
        for (int b = nbits - 1; b >= 0; b--) begin
            if (!pha) begin
                spi_mosi = mo[b];
                wait_clk(H);
                mi = {mi[14:0], spi_miso};
                spi_sck = ~pol;
                wait_clk(H);
                spi_sck = pol;
            end else begin
                spi_sck = ~pol;
                spi_mosi = mo[b];
                wait_clk(H);
                mi = {mi[14:0], spi_miso};
                spi_sck = pol;
                wait_clk(H);
            end
        end
    endtask

    task automatic sel(input bit lvl);
        spi_sel = lvl;
        wait_clk(H);
    endtask

    logic [15:0] v, mi, tx, mo, exp_rx;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%h expected=%h", 16'h0, 16'h1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check(v == 16'h0, "R1 reset read", v, 16'h0);
        end
        check(irq == 1'b0 && spi_miso == 1'b0, "R1 irq/miso", {14'h0, irq, spi_miso}, 16'h0);

        // R2 reserved bits, R3 divider
        wr(2'd0, 16'h00FF);
        rd(2'd0, v);
        check(v == 16'h00C7, "R2 setup readback", v, 16'h00C7);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h00A7);
        rd(2'd1, v);
        check(v == 16'h00A7, "R3 divider readback", v, 16'h00A7);

        // Sweep: mode x length x select level x pattern (R5 R6 R7 R8 R10 R13)
        for (int m = 0; m < 32; m++) begin
            automatic bit pol = m[0], pha = m[1], wide = m[2], ahi = m[3], ie = m[4];
            automatic int nb = wide ? 16 : 8;
            tx = 16'hA5C3 ^ (16'(m) * 16'h1357);
            mo = ~{tx[7:0], tx[15:8]} ^ 16'(m);
            wr(2'd0, {8'h0, ie, ahi, 3'b000, wide, pha, pol});
            spi_sck = pol;
            sel(~ahi);
            wr(2'd3, 16'h0000);
            wr(2'd2, tx);
            mi = '0;
            sel(ahi);
            bits(pol, pha, nb, mo, mi);
            sel(~ahi);
            wait_clk(4);
            v = wide ? tx : {8'h00, tx[7:0]};
            check((mi & (wide ? 16'hFFFF : 16'h00FF)) == v,
                  wide ? "R6 R5 miso 16b" : "R7 R5 miso 8b", mi, v);
            exp_rx = wide ? mo : {8'h00, mo[7:0]};
            rd(2'd2, v);
            check(v == exp_rx, wide ? "R6 R8 rx 16b" : "R7 R8 rx 8b", v, exp_rx);
            rd(2'd3, v);
            check(v == 16'h0001, "R10 done flag", v, 16'h0001);
            check(irq == ie, "R13 irq", {15'h0, irq}, {15'h0, ie});
        end
        rd(2'd1, v);
        check(v == 16'h00A7, "R3 divider held", v, 16'h00A7);

        // R4 select inactive ignores clock; R14 abort
        wr(2'd0, 16'h0081);   // ie, active low, 8-bit, pha0, pol1
        spi_sck = 1'b1;
        sel(1'b1);
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'h003C);
        mi = '0;
        bits(1'b1, 1'b0, 8, 16'h00F0, mi);
        rd(2'd3, v);
        check(v == 16'h0000, "R4 no completion when deselected", v, 16'h0);
        check(mi == 16'h0000, "R4 miso idle 0", mi, 16'h0);
        rd(2'd2, v);
        check(v == exp_rx, "R4 rx unchanged", v, exp_rx);
        sel(1'b0);
        mi = '0;
        bits(1'b1, 1'b0, 5, 16'h001F, mi);
        sel(1'b1);
        rd(2'd3, v);
        check(v == 16'h0000, "R14 aborted char no done", v, 16'h0);
        sel(1'b0);
        mi = '0;
        bits(1'b1, 1'b0, 8, 16'h0069, mi);
        sel(1'b1);
        rd(2'd2, v);
        check(v == 16'h0069, "R14 fresh char after abort", v, 16'h0069);
        check(mi == 16'h003C, "R14 miso fresh char", mi, 16'h003C);

        // R11 overrun, R9 collision
        wr(2'd3, 16'h0000);
        sel(1'b0);
        mi = '0;
        bits(1'b1, 1'b0, 8, 16'h0011, mi);
        wr(2'd2, 16'hBEEF);
        bits(1'b1, 1'b0, 8, 16'h0022, mi);
        sel(1'b1);
        rd(2'd3, v);
        check(v == 16'h0007, "R11 R9 done+ovr+wcol", v, 16'h0007);
        rd(2'd2, v);
        check(v == 16'h0011, "R11 rx kept", v, 16'h0011);
        check(mi == 16'h3C3C, "R9 R10 tx not overwritten, repeated", mi, 16'h3C3C);

        // R12 clear by writing 0
        wr(2'd3, 16'h000D);
        rd(2'd3, v);
        check(v == 16'h0005, "R12 clear ovr only", v, 16'h0005);
        wr(2'd3, 16'h0000);
        rd(2'd3, v);
        check(v == 16'h0000, "R12 clear all", v, 16'h0000);
        check(irq == 1'b0, "R13 irq low after clear", {15'h0, irq}, 16'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule